// File: doc/BRIEF.md
# Lockable Multi-Pipe Descriptor Arbiter

This block shares one downstream descriptor engine among several DMA pipes. Each pipe has a doorbell input. A pulse on it adds one descriptor to that pipe's saturating pending counter. When no fetch is outstanding, the arbiter chooses one pipe that has pending work and drives a one-cycle fetch grant for it. It then waits for that descriptor to come back before it issues the next grant. The descriptor returns with a 16-bit flags word, which the block decodes.

Each pipe belongs to a configurable group. A command descriptor can ask to lock the engine for its group. While the lock is held, pipes of every other group keep counting doorbells but receive no grants. A later command descriptor that asks for release, and that comes from the owning group, frees all of them at once. Two flag bits are not interpreted here and are copied to outputs alongside a completion pulse.

Top module: `pipe_lock_arbiter`

## Requirements
- R1: After a synchronous reset every pending count is zero, no grant is driven, `lock_active_o` is 0, `lock_grp_o` is 0, every pipe is in group 0 and `desc_done_o` is 0.
- R2: At most one fetch grant is outstanding. A grant is a one-cycle one-hot pulse, and the next grant can come only after `desc_valid_i` returns the descriptor. Eligible pipes are served in round-robin order, and after reset the search starts at pipe 0.
- R3: Each pending count saturates at 2^CNT_W-1, which is 15 by default. Doorbells that arrive at the limit are lost. Every counted descriptor is granted exactly once.
- R4: When a doorbell and a grant hit the same pipe in the same cycle, that pipe's pending count is left unchanged.
- R5: In the flags word, bit 11 marks a command descriptor, bit 10 requests a lock and bit 9 requests a release. Bits 10 and 9 take effect only when bit 11 is also set. Otherwise the lock state and the owner are left untouched.
- R6: When an accepted command descriptor requests a lock while the engine is unlocked, `lock_active_o` rises in the next cycle and `lock_grp_o` takes the group of the returning pipe. From then on, only pipes of that group are granted.
- R7: A pipe outside the owning group gets no grant while the lock is held, but its doorbells are still counted. After release its counted descriptors are granted.
- R8: A release command from a pipe of the owning group clears `lock_active_o` and makes all blocked pipes eligible together. A release from any other group is ignored.
- R9: A lock request that arrives while the lock is already held leaves `lock_active_o` and `lock_grp_o` unchanged.
- R10: A command descriptor that sets both bit 10 and bit 9 leaves the block unlocked, with `lock_grp_o` set to its pipe's group.
- R11: One cycle after a descriptor is accepted, `desc_done_o` pulses. `desc_eob_o` and `desc_nwd_o` carry flag bits 13 and 12 of that descriptor.
- R12: A configuration write sets a pipe's group only while no fetch is outstanding. A write made while a fetch is outstanding is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| doorbell_i | input | NUM_PIPES | Per-pipe pulse that adds one pending descriptor |
| cfg_we_i | input | 1 | Group table write strobe |
| cfg_pipe_i | input | PIPE_W | Pipe whose group is written |
| cfg_grp_i | input | GRP_W | Group value to write |
| desc_valid_i | input | 1 | Descriptor for the outstanding grant is present |
| desc_flags_i | input | 16 | Flags word of that descriptor |
| fetch_grant_o | output | NUM_PIPES | One-hot fetch grant pulse |
| desc_done_o | output | 1 | Descriptor accepted pulse |
| desc_eob_o | output | 1 | Flag bit 13 of the accepted descriptor |
| desc_nwd_o | output | 1 | Flag bit 12 of the accepted descriptor |
| lock_active_o | output | 1 | Engine is locked to one group |
| lock_grp_o | output | GRP_W | Group owning or last taking the lock |

## Verification
A doorbell and a grant can land on the same pipe's counter in the same cycle. The bench provokes this by holding a doorbell for two consecutive cycles on an idle pipe: the first edge raises the count to one, and the second edge issues a grant at the same moment it receives the second doorbell. The scoreboard expects two grants for that pipe. A lost increment would show up as a missing second grant, and a lost decrement as a third grant that nobody expects.

// File: rtl/pla_pkg.sv
package pla_pkg;

  localparam int FLAGS_W    = 16;
  localparam int FB_EOB     = 13;
  localparam int FB_NWD     = 12;
  localparam int FB_CMD     = 11;
  localparam int FB_LOCK    = 10;
  localparam int FB_UNLOCK  = 9;

  typedef struct packed {
    logic take;
    logic release_req;
    logic eob;
    logic nwd;
  } flag_dec_t;

  function automatic flag_dec_t decode_flags(input logic [FLAGS_W-1:0] f);
    flag_dec_t d;
    d.take        = f[FB_CMD] & f[FB_LOCK];
    d.release_req = f[FB_CMD] & f[FB_UNLOCK];
    d.eob         = f[FB_EOB];
    d.nwd         = f[FB_NWD];
    return d;
  endfunction

endpackage

// File: rtl/pla_pend_ctr.sv
module pla_pend_ctr #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc_i,
  input  logic dec_i,
  output logic nonzero_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign nonzero_o = (cnt_q != '0);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && inc_i && !dec_i) |=> (cnt_q == CNT_MAX)); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> (cnt_q != '0)); // R3

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inc_i && dec_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/pla_rr_pick.sv
module pla_rr_pick #(
  parameter int NUM_PIPES = 4,
  localparam int PIPE_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic [NUM_PIPES-1:0] req_i,
  input  logic [PIPE_W-1:0]    last_i,
  output logic                 valid_o,
  output logic [PIPE_W-1:0]    idx_o
);

  always_comb begin
    int j;
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 1; k <= NUM_PIPES; k++) begin
      j = (int'(last_i) + k) % NUM_PIPES;
      if (!valid_o && req_i[j]) begin
        valid_o = 1'b1;
        idx_o   = PIPE_W'(j);
      end
    end
  end

endmodule

// File: rtl/pla_lock_ctrl.sv
module pla_lock_ctrl
  import pla_pkg::*;
#(
  parameter int GRP_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire_i,
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic [GRP_W-1:0]   grp_i,
  output logic               lock_o,
  output logic [GRP_W-1:0]   owner_o
);

  flag_dec_t        dec;
  logic             lock_q;
  logic [GRP_W-1:0] owner_q;
  logic             own_match;

  assign dec       = decode_flags(flags_i);
  assign own_match = (owner_q == grp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
    end else if (fire_i) begin
      if (dec.take && dec.release_req) begin
        if (!lock_q || own_match) begin
          lock_q  <= 1'b0;
          owner_q <= grp_i;
        end
      end else if (dec.take) begin
        if (!lock_q) begin
          lock_q  <= 1'b1;
          owner_q <= grp_i;
        end
      end else if (dec.release_req) begin
        if (lock_q && own_match) lock_q <= 1'b0;
      end
    end
  end

  assign lock_o  = lock_q;
  assign owner_o = owner_q;

  AST_LOCK_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(fire_i && flags_i[FB_CMD] && flags_i[FB_LOCK])); // R5

  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (rst)
    (lock_q && $past(lock_q)) |-> (owner_q == $past(owner_q))); // R9

  AST_RELEASE_BY_OWNER: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_q) |-> $past(fire_i && flags_i[FB_CMD] && flags_i[FB_UNLOCK] && own_match)); // R8

endmodule

// File: rtl/pipe_lock_arbiter.sv
module pipe_lock_arbiter
  import pla_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int GRP_W     = 2,
  parameter int CNT_W     = 4,
  localparam int PIPE_W   = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PIPES-1:0] doorbell_i,
  input  logic                 cfg_we_i,
  input  logic [PIPE_W-1:0]    cfg_pipe_i,
  input  logic [GRP_W-1:0]     cfg_grp_i,
  input  logic                 desc_valid_i,
  input  logic [FLAGS_W-1:0]   desc_flags_i,
  output logic [NUM_PIPES-1:0] fetch_grant_o,
  output logic                 desc_done_o,
  output logic                 desc_eob_o,
  output logic                 desc_nwd_o,
  output logic                 lock_active_o,
  output logic [GRP_W-1:0]     lock_grp_o
);

  logic [GRP_W-1:0]     grp_tbl [NUM_PIPES];
  logic [NUM_PIPES-1:0] pend_nz;
  logic [NUM_PIPES-1:0] elig;
  logic [NUM_PIPES-1:0] req;
  logic [NUM_PIPES-1:0] gnt_vec;
  logic                 pick_valid;
  logic [PIPE_W-1:0]    pick_idx;
  logic [PIPE_W-1:0]    last_q;
  logic [PIPE_W-1:0]    cur_q;
  logic                 busy_q;
  logic                 desc_fire;
  logic [GRP_W-1:0]     gnt_grp_q;
  flag_dec_t            fdec;

  assign desc_fire = busy_q && desc_valid_i;
  assign fdec      = decode_flags(desc_flags_i);

  // group table, written only when no fetch is outstanding
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PIPES; p++) grp_tbl[p] <= '0;
    end else if (cfg_we_i && !busy_q && (int'(cfg_pipe_i) < NUM_PIPES)) begin
      grp_tbl[cfg_pipe_i] <= cfg_grp_i;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      assign elig[p]    = pend_nz[p] && (!lock_active_o || (grp_tbl[p] == lock_grp_o));
      assign gnt_vec[p] = pick_valid && (pick_idx == PIPE_W'(p));

      pla_pend_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk       (clk),
        .rst       (rst),
        .inc_i     (doorbell_i[p]),
        .dec_i     (gnt_vec[p]),
        .nonzero_o (pend_nz[p])
      );
    end
  endgenerate

  assign req = busy_q ? '0 : elig;

  pla_rr_pick #(.NUM_PIPES(NUM_PIPES)) i_pick (
    .req_i   (req),
    .last_i  (last_q),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q        <= 1'b0;
      last_q        <= PIPE_W'(NUM_PIPES - 1);
      cur_q         <= '0;
      gnt_grp_q     <= '0;
      fetch_grant_o <= '0;
      desc_done_o   <= 1'b0;
      desc_eob_o    <= 1'b0;
      desc_nwd_o    <= 1'b0;
    end else begin
      fetch_grant_o <= gnt_vec;
      if (pick_valid) begin
        busy_q    <= 1'b1;
        cur_q     <= pick_idx;
        last_q    <= pick_idx;
        gnt_grp_q <= grp_tbl[pick_idx];
      end else if (desc_fire) begin
        busy_q <= 1'b0;
      end
      desc_done_o <= desc_fire;
      desc_eob_o  <= desc_fire && fdec.eob;
      desc_nwd_o  <= desc_fire && fdec.nwd;
    end
  end

  pla_lock_ctrl #(.GRP_W(GRP_W)) i_lock (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (desc_fire),
    .flags_i (desc_flags_i),
    .grp_i   (grp_tbl[cur_q]),
    .lock_o  (lock_active_o),
    .owner_o (lock_grp_o)
  );

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fetch_grant_o)); // R2

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (|fetch_grant_o) |=> (fetch_grant_o == '0)); // R2

  AST_LOCK_CONFINES: assert property (@(posedge clk) disable iff (rst)
    ((|fetch_grant_o) && $past(lock_active_o)) |-> (gnt_grp_q == $past(lock_grp_o))); // R6

  AST_DONE_AFTER_DESC: assert property (@(posedge clk) disable iff (rst)
    desc_done_o |-> $past(desc_valid_i)); // R11

endmodule

// File: tb/test_pipe_lock_arbiter.sv
module test_pipe_lock_arbiter;

  localparam int NP = 4;
  localparam int GW = 2;
  localparam logic [15:0] F_EOB = 16'h2000;
  localparam logic [15:0] F_NWD = 16'h1000;
  localparam logic [15:0] F_CMD = 16'h0800;
  localparam logic [15:0] F_LCK = 16'h0400;
  localparam logic [15:0] F_ULK = 16'h0200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] doorbell = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_pipe = '0;
  logic [GW-1:0] cfg_grp = '0;
  logic          desc_valid = 1'b0;
  logic [15:0]   desc_flags = '0;
  logic [NP-1:0] grant;
  logic          done, eob, nwd, lock_act;
  logic [GW-1:0] lock_grp;

  logic [15:0] resp_flags [NP];
  logic [15:0] sent_flags = '0;
  int          exp_q[$];
  string       tag_q[$];
  int          n_checks = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  pipe_lock_arbiter #(.NUM_PIPES(NP), .GRP_W(GW), .CNT_W(4)) i_pipe_lock_arbiter (
    .clk(clk), .rst(rst), .doorbell_i(doorbell),
    .cfg_we_i(cfg_we), .cfg_pipe_i(cfg_pipe), .cfg_grp_i(cfg_grp),
    .desc_valid_i(desc_valid), .desc_flags_i(desc_flags),
    .fetch_grant_o(grant), .desc_done_o(done), .desc_eob_o(eob), .desc_nwd_o(nwd),
    .lock_active_o(lock_act), .lock_grp_o(lock_grp)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int grant_idx(input logic [NP-1:0] g);
    int r = -1;
    for (int i = 0; i < NP; i++) if (g[i]) r = i;
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && grant != '0) begin
      int idx;
      idx = grant_idx(grant);
      chk($onehot(grant), "R2", "grant not one-hot", int'(grant), 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected grant to pipe", idx, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(idx == e, t, "grant pipe", idx, e);
      end
    end
    if (!rst && done) begin
      chk(eob == sent_flags[13], "R11", "eob pass-through", int'(eob), int'(sent_flags[13]));
      chk(nwd == sent_flags[12], "R11", "nwd pass-through", int'(nwd), int'(sent_flags[12]));
    end
  end

  // descriptor responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && grant != '0) begin
        int p;
        p = grant_idx(grant);
        @(posedge clk);
        @(posedge clk);
        #1;
        desc_valid = 1'b1;
        desc_flags = resp_flags[p];
        sent_flags = resp_flags[p];
        @(posedge clk);
        #1;
        desc_valid = 1'b0;
        desc_flags = '0;
      end
    end
  end

  task automatic expect_grant(input int p, input string t);
    exp_q.push_back(p);
    tag_q.push_back(t);
  endtask

  task automatic ring(input logic [NP-1:0] m);
    @(posedge clk); #1 doorbell = m;
    @(posedge clk); #1 doorbell = '0;
  endtask

  task automatic set_grp(input int p, input int g);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_pipe = 2'(p); cfg_grp = GW'(g);
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic chk_lock(input string req, input logic a, input int g);
    @(negedge clk);
    chk(lock_act == a, req, "lock_active", int'(lock_act), int'(a));
    chk(int'(lock_grp) == g, req, "lock_grp", int'(lock_grp), g);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) resp_flags[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(grant == '0, "R1", "grant after reset", int'(grant), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk_lock("R1", 1'b0, 0);

    // R2 round robin from pipe 0
    for (int i = 0; i < NP; i++) expect_grant(i, "R2");
    ring(4'b1111);
    drain();
    // R2 fairness between two busy pipes
    expect_grant(0, "R2"); expect_grant(2, "R2");
    expect_grant(0, "R2"); expect_grant(2, "R2");
    ring(4'b0101);
    ring(4'b0101);
    drain();

    // groups: pipes 0,1 -> 1, pipes 2,3 stay 0
    set_grp(0, 1);
    set_grp(1, 1);

    // R6 take the lock from pipe 1
    resp_flags[1] = F_CMD | F_LCK;
    expect_grant(1, "R6");
    ring(4'b0010);
    drain();
    resp_flags[1] = '0;
    chk_lock("R6", 1'b1, 1);

    // R7 / R3 blocked pipes keep counting, saturate at 15
    for (int i = 0; i < 20; i++) ring(4'b0100);
    ring(4'b1000);
    repeat (10) @(posedge clk);
    chk_lock("R7", 1'b1, 1);

    // R9 second lock from the owning group changes nothing
    resp_flags[0] = F_CMD | F_LCK;
    expect_grant(0, "R9");
    ring(4'b0001);
    drain();
    chk_lock("R9", 1'b1, 1);

    // R8 release by owner, then blocked work is served (R7, R3)
    resp_flags[0] = F_CMD | F_ULK;
    expect_grant(0, "R8");
    expect_grant(2, "R7");
    expect_grant(3, "R7");
    for (int i = 0; i < 14; i++) expect_grant(2, "R3");
    ring(4'b0001);
    drain();
    resp_flags[0] = '0;
    chk_lock("R8", 1'b0, 1);

    // R5 lock bit without command bit is ignored
    resp_flags[2] = F_LCK | F_ULK;
    expect_grant(2, "R5");
    ring(4'b0100);
    drain();
    resp_flags[2] = '0;
    chk_lock("R5", 1'b0, 1);

    // R10 lock and unlock in one command descriptor
    resp_flags[3] = F_CMD | F_LCK | F_ULK;
    expect_grant(3, "R10");
    ring(4'b1000);
    drain();
    resp_flags[3] = '0;
    chk_lock("R10", 1'b0, 0);

    // R4 doorbell and grant on the same pipe in the same cycle; R11 flags
    resp_flags[1] = F_EOB | F_NWD;
    expect_grant(1, "R4");
    expect_grant(1, "R4");
    @(posedge clk); #1 doorbell = 4'b0010;
    @(posedge clk); #1 doorbell = 4'b0010;
    @(posedge clk); #1 doorbell = '0;
    drain();
    resp_flags[1] = F_NWD;
    expect_grant(1, "R11");
    ring(4'b0010);
    drain();
    resp_flags[1] = '0;

    // R12 configuration write during an outstanding fetch is dropped
    expect_grant(1, "R12");
    @(posedge clk); #1 doorbell = 4'b0010;
    @(posedge clk); #1 doorbell = '0;
    while (grant == '0) @(negedge clk);
    cfg_we = 1'b1; cfg_pipe = 2'd1; cfg_grp = '0;
    @(posedge clk); #1 cfg_we = 1'b0;
    drain();
    resp_flags[0] = F_CMD | F_LCK;
    expect_grant(0, "R12");
    ring(4'b0001);
    drain();
    resp_flags[0] = '0;
    chk_lock("R12", 1'b1, 1);
    resp_flags[1] = F_CMD | F_ULK;
    expect_grant(1, "R12");
    expect_grant(2, "R8");
    ring(4'b0110);
    drain();
    resp_flags[1] = '0;
    chk_lock("R8", 1'b0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule